// File: doc/BRIEF.md
# FIFO-mode DMA ready and interrupt generator for a UART channel

This block produces the three host-side handshake outputs for one UART channel. It assumes the channel has receive and transmit FIFOs and signals DMA readiness. It sees the receive FIFO occupancy, a receive-timeout pulse, the transmit FIFO occupancy, the programmed trigger levels, the host's data-read and status-read strobes, and two interrupt enables. From these it drives an active-low receive-ready, an active-low transmit-ready and an active-high interrupt request.

The FIFOs, shifters, baud generation, timeout counting and registers live elsewhere; this block only consumes their status. Receive-ready has hysteresis. It asserts at the trigger level or on a timeout, and it holds while the host drains the FIFO until the FIFO is empty. The transmit interrupt is raised by the transmit FIFO running empty. It has two independent clear paths: a status read, or the FIFO refilling to its trigger.

Top module: `uart_dma_rdy_int`

## Requirements
- R1: `rxrdy_n` goes low one clock after `rx_fill >= rx_trig` or a one-cycle `rx_to_pulse`.
- R2: Once low, `rxrdy_n` stays low while `rx_fill` is nonzero, even below the trigger. It returns high one clock after `rx_fill == 0`.
- R3: With `ier_rx_en` = 1, the receive interrupt sets one clock after the events of R1. It drops one clock after `rx_fill < rx_trig` once no timeout flag is pending.
- R4: A timeout pulse sets a sticky flag that keeps the receive interrupt up. The flag clears one clock after a data read (`rd_data_stb`) or after `rx_fill == 0`, and it does not return on later fill changes.
- R5: `txrdy_n` is high one clock after `tx_fill >= tx_trig` and low one clock after `tx_fill < tx_trig`. This holds at the extremes, trigger 1 and trigger 128.
- R6: With `ier_tx_en` = 1, the transmit interrupt sets one clock after `tx_fill` changes from nonzero to 0. With `ier_tx_en` = 0 it never sets and any pending one is dropped.
- R7: The transmit interrupt clears one clock after `rd_isr_stb` or after `tx_fill >= tx_trig`, whichever comes first. It does not re-arm until the FIFO empties again.
- R8: `irq` is high while either interrupt is pending. It stays high until both have been cleared.
- R9: Synchronous reset gives `rxrdy_n` = 1, `txrdy_n` = 0 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_fill | input | FILL_W (8) | Receive FIFO occupancy, 0..DEPTH |
| rx_trig | input | FILL_W (8) | Receive trigger level, 1..DEPTH |
| rx_to_pulse | input | 1 | One-cycle receive data timeout |
| tx_fill | input | FILL_W (8) | Transmit FIFO occupancy, 0..DEPTH |
| tx_trig | input | FILL_W (8) | Transmit trigger level, 1..DEPTH |
| rd_data_stb | input | 1 | One-cycle host read of the receive data register |
| rd_isr_stb | input | 1 | One-cycle host read of the interrupt status register |
| ier_rx_en | input | 1 | Receive data interrupt enable |
| ier_tx_en | input | 1 | Transmit empty interrupt enable |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default DEPTH of 128, so the occupancy and trigger fields are 8 bits wide. This makes both extremes reachable directly: a trigger of 1 and a full FIFO of 128 entries. At these values the comparators must handle the top bit of the field. Mid-range triggers of 4, 8 and 16 are used to show the hysteresis band, which lies between the trigger and empty. The clear paths of the two interrupts are tried alone and overlapping.

// File: rtl/uart_dma_pkg.sv
// Package: shared types for the DMA ready / interrupt logic.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_dma_pkg;
    // Receive ready state: idle (not ready) or draining (ready held low).
    typedef enum logic {
        RXS_IDLE  = 1'b0,
        RXS_DRAIN = 1'b1
    } rx_state_e;
endpackage

// File: rtl/uart_dma_rx_ctl.sv
// Module: receive-side ready and interrupt control.
// Does: holds receive-ready from trigger/timeout until the FIFO empties;
//       keeps a sticky timeout flag; raises the receive interrupt request.
// Assumes: rx_trig in 1..DEPTH, rx_to_pulse only while data is present.
module uart_dma_rx_ctl
    import uart_dma_pkg::*;
#(
    parameter int FILL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] rx_trig,
    input  logic              rx_to_pulse,
    input  logic              rd_data_stb,
    input  logic              ier_rx_en,
    output logic              rxrdy_n,
    output logic              rx_int
);
    rx_state_e state_q, state_d;
    logic      to_flag_q, to_flag_d;
    logic      at_trig, is_empty;

    // Level comparisons used by every process below.
    always_comb begin
        at_trig  = (rx_fill >= rx_trig);
        is_empty = (rx_fill == '0);
    end

    // Timeout flag: a new pulse wins; a data read or empty FIFO clears it.
    always_comb begin
        if (rx_to_pulse)
            to_flag_d = 1'b1;
        else if (rd_data_stb || is_empty)
            to_flag_d = 1'b0;
        else
            to_flag_d = to_flag_q;
    end

    // Ready state: enter drain at trigger or timeout, leave only when empty.
    always_comb begin
        state_d = state_q;
        case (state_q)
            RXS_IDLE:  if (at_trig || rx_to_pulse) state_d = RXS_DRAIN;
            RXS_DRAIN: if (is_empty && !rx_to_pulse) state_d = RXS_IDLE;
            default:   state_d = RXS_IDLE;
        endcase
    end

    // State, flag and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RXS_IDLE;
            to_flag_q <= 1'b0;
            rx_int    <= 1'b0;
        end else begin
            state_q   <= state_d;
            to_flag_q <= to_flag_d;
            rx_int    <= ier_rx_en && (at_trig || to_flag_d);
        end
    end

    // Output drive: ready is active low while draining.
    always_comb rxrdy_n = (state_q != RXS_DRAIN);

    a_r1_rx_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill >= rx_trig || rx_to_pulse) |=> !rxrdy_n);
    a_r2_rx_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxrdy_n && rx_fill != '0) |=> !rxrdy_n);
    a_r2_rx_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == '0 && !rx_to_pulse) |=> rxrdy_n);
    a_r3_rx_int_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_flag_q && !rx_to_pulse && rx_fill < rx_trig) |=> !rx_int);
    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_stb && !rx_to_pulse) |=> !to_flag_q);
endmodule

// File: rtl/uart_dma_tx_ctl.sv
// Module: transmit-side ready and empty-interrupt control.
// Does: drives transmit-ready from the trigger comparison; sets the
//       transmit interrupt on the FIFO-empty transition, clears it on a
//       status read or refill to trigger.
// Assumes: tx_trig in 1..DEPTH; FIFO empty at reset.
module uart_dma_tx_ctl #(
    parameter int FILL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [FILL_W-1:0] tx_trig,
    input  logic              rd_isr_stb,
    input  logic              ier_tx_en,
    output logic              txrdy_n,
    output logic              tx_int
);
    logic empty_q;
    logic now_empty, went_empty, refilled, clr_req;

    // Event decode: empty edge, refill to trigger, any clear request.
    always_comb begin
        now_empty  = (tx_fill == '0);
        went_empty = now_empty && !empty_q;
        refilled   = (tx_fill >= tx_trig);
        clr_req    = rd_isr_stb || refilled;
    end

    // Registers: empty history, ready level, pending interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            txrdy_n <= 1'b0;
            tx_int  <= 1'b0;
        end else begin
            empty_q <= now_empty;
            txrdy_n <= refilled;
            tx_int  <= ier_tx_en && (went_empty || (tx_int && !clr_req));
        end
    end

    a_r5_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fill >= tx_trig) |=> txrdy_n);
    a_r5_tx_room: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fill < tx_trig) |=> !txrdy_n);
    a_r6_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_tx_en |=> !tx_int);
    a_r7_tx_isr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr_stb && tx_fill != '0) |=> !tx_int);
endmodule

// File: rtl/uart_dma_rdy_int.sv
// Module: top of the FIFO-mode DMA ready / interrupt generator.
// Does: instantiates receive and transmit controls, merges their
//       interrupt requests into one active-high line.
// Assumes: fill counts 0..DEPTH, trigger levels 1..DEPTH, strobes one cycle.
module uart_dma_rdy_int #(
    parameter int DEPTH  = 128,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] rx_trig,
    input  logic              rx_to_pulse,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [FILL_W-1:0] tx_trig,
    input  logic              rd_data_stb,
    input  logic              rd_isr_stb,
    input  logic              ier_rx_en,
    input  logic              ier_tx_en,
    output logic              rxrdy_n,
    output logic              txrdy_n,
    output logic              irq
);
    logic rx_int_w, tx_int_w;

    uart_dma_rx_ctl #(.FILL_W(FILL_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_fill    (rx_fill),
        .rx_trig    (rx_trig),
        .rx_to_pulse(rx_to_pulse),
        .rd_data_stb(rd_data_stb),
        .ier_rx_en  (ier_rx_en),
        .rxrdy_n    (rxrdy_n),
        .rx_int     (rx_int_w)
    );

    uart_dma_tx_ctl #(.FILL_W(FILL_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_fill   (tx_fill),
        .tx_trig   (tx_trig),
        .rd_isr_stb(rd_isr_stb),
        .ier_tx_en (ier_tx_en),
        .txrdy_n   (txrdy_n),
        .tx_int    (tx_int_w)
    );

    // Merge: line stays up until every source has cleared.
    always_comb irq = rx_int_w || tx_int_w;

    a_r8_rx_keeps_line: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rx_en && rx_fill >= rx_trig) |=> irq);
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (rxrdy_n && !txrdy_n && !irq));
endmodule

// File: tb/uart_dma_rdy_int_bench.sv
module uart_dma_rdy_int_bench;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] rx_fill = '0, rx_trig = 8'd8, tx_fill = '0, tx_trig = 8'd4;
    logic          rx_to_pulse = 1'b0, rd_data_stb = 1'b0, rd_isr_stb = 1'b0;
    logic          ier_rx_en = 1'b0, ier_tx_en = 1'b0;
    logic          rxrdy_n, txrdy_n, irq;
    int            checks = 0, failures = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    uart_dma_rdy_int u_uart_dma_rdy_int (
        .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_trig(rx_trig),
        .rx_to_pulse(rx_to_pulse), .tx_fill(tx_fill), .tx_trig(tx_trig),
        .rd_data_stb(rd_data_stb), .rd_isr_stb(rd_isr_stb),
        .ier_rx_en(ier_rx_en), .ier_tx_en(ier_tx_en),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .irq(irq)
    );

    // One clock, then settle 1 ns past the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        chk("R9 rxrdy_n", rxrdy_n, 1'b1);
        chk("R9 txrdy_n", txrdy_n, 1'b0);
        chk("R9 irq", irq, 1'b0);
        rst_n = 1'b1; step();
    endtask

    task automatic t_rx_trigger();
        ier_rx_en = 1; rx_trig = 8'd8;
        rx_fill = 8'd7; step();
        chk("R1 below trig", rxrdy_n, 1'b1);
        chk("R3 below trig", irq, 1'b0);
        rx_fill = 8'd8; step();
        chk("R1 at trig", rxrdy_n, 1'b0);
        chk("R3 at trig", irq, 1'b1);
        rx_fill = 8'd5; step();
        chk("R2 hold below trig", rxrdy_n, 1'b0);
        chk("R3 drop below trig", irq, 1'b0);
        rx_fill = 8'd1; step();
        chk("R2 hold at one", rxrdy_n, 1'b0);
        rx_fill = 8'd0; step();
        chk("R2 release empty", rxrdy_n, 1'b1);
        rx_trig = 8'd1; rx_fill = 8'd1; step();
        chk("R1 trig one", rxrdy_n, 1'b0);
        rx_fill = 8'd0; step();
        ier_rx_en = 0;
    endtask

    task automatic t_timeout();
        ier_rx_en = 1; rx_trig = 8'd16;
        rx_fill = 8'd3; rx_to_pulse = 1; step();
        rx_to_pulse = 0;
        chk("R1 timeout ready", rxrdy_n, 1'b0);
        chk("R3 timeout int", irq, 1'b1);
        step();
        chk("R4 flag sticky", irq, 1'b1);
        rd_data_stb = 1; rx_fill = 8'd2; step();
        rd_data_stb = 0;
        chk("R4 read clears", irq, 1'b0);
        chk("R2 still draining", rxrdy_n, 1'b0);
        rx_fill = 8'd0; step();
        chk("R2 empty release", rxrdy_n, 1'b1);
        rx_fill = 8'd2; rx_to_pulse = 1; step();
        rx_to_pulse = 0; rx_fill = 8'd0; step();
        chk("R4 empty clears", irq, 1'b0);
        rx_fill = 8'd2; step();
        chk("R4 no return", irq, 1'b0);
        rx_fill = 8'd0; step();
        ier_rx_en = 0;
    endtask

    task automatic t_tx_level();
        tx_trig = 8'd4;
        tx_fill = 8'd3; step();
        chk("R5 below", txrdy_n, 1'b0);
        tx_fill = 8'd4; step();
        chk("R5 at trig", txrdy_n, 1'b1);
        tx_fill = 8'd3; step();
        chk("R5 back below", txrdy_n, 1'b0);
        tx_trig = 8'd128; tx_fill = 8'd128; step();
        chk("R5 full 128", txrdy_n, 1'b1);
        tx_fill = 8'd127; step();
        chk("R5 127 of 128", txrdy_n, 1'b0);
        tx_trig = 8'd1; tx_fill = 8'd1; step();
        chk("R5 trig one", txrdy_n, 1'b1);
        tx_fill = 8'd0; tx_trig = 8'd4; step();
    endtask

    task automatic t_tx_int();
        ier_tx_en = 1; tx_trig = 8'd4;
        tx_fill = 8'd2; step();
        chk("R6 no int with data", irq, 1'b0);
        tx_fill = 8'd0; step();
        chk("R6 empty sets", irq, 1'b1);
        step();
        chk("R6 held", irq, 1'b1);
        rd_isr_stb = 1; step();
        rd_isr_stb = 0;
        chk("R7 isr read clears", irq, 1'b0);
        step();
        chk("R7 no rearm", irq, 1'b0);
        tx_fill = 8'd3; step();
        tx_fill = 8'd0; step();
        chk("R6 second empty", irq, 1'b1);
        tx_fill = 8'd4; step();
        chk("R7 refill clears", irq, 1'b0);
        ier_tx_en = 0;
        tx_fill = 8'd2; step();
        tx_fill = 8'd0; step();
        chk("R6 masked", irq, 1'b0);
    endtask

    task automatic t_combined();
        ier_rx_en = 1; ier_tx_en = 1; rx_trig = 8'd8; tx_trig = 8'd4;
        tx_fill = 8'd2; rx_fill = 8'd8; step();
        tx_fill = 8'd0; step();
        chk("R8 both pending", irq, 1'b1);
        rd_isr_stb = 1; step();
        rd_isr_stb = 0;
        chk("R8 rx still holds", irq, 1'b1);
        rx_fill = 8'd0; step();
        chk("R8 both cleared", irq, 1'b0);
        ier_rx_en = 0; ier_tx_en = 0;
    endtask

    initial begin
        t_reset();
        t_rx_trigger();
        t_timeout();
        t_tx_level();
        t_tx_int();
        t_combined();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule